// File: doc/BRIEF.md
# Edge-Triggered Interrupt Vector Arbiter

This block turns four trigger pins into interrupt vector numbers for a small sequencer. Each pin idles high, is synchronised, and is then debounced. A level change counts only after it has held for a full debounce window. The window length is chosen at run time by a mode bit, from two lengths that are parameters counted in clock cycles. Every debounced falling edge and rising edge is a separate interrupt source with its own enable bit and its own fixed vector number.

Two more sources sit around the eight edge sources. A power-on request is raised once, a fixed number of cycles after reset. A software jump request carries its own target vector. All ten sources are latched as pending and resolved by a fixed priority. The winning vector is shown on `vec_o` together with a one-cycle `vec_valid_o` strobe.

The output stream uses back-pressure through `vec_ack_i`. After a strobe, no further strobe appears until the consumer pulses the acknowledge. An acknowledge given while no vector is outstanding has no effect. Requests that lose arbitration, or that arrive while a vector is outstanding, stay pending. Requests from a disabled edge are dropped.

Top module: `trig_vec_arb`

## Requirements
- R1: While reset is asserted, and after it until the power-on vector, `vec_valid_o` is low. After reset, register 0 bit 4 is 1 (long debounce) and every edge enable is 1.
- R2: A single power-on vector of value 32 is issued POI_DELAY_CYC to POI_DELAY_CYC+3 cycles after reset is released, and never again.
- R3: A pin level change is accepted only after it has held for DEB_LONG_CYC cycles (register 0 bit 4 = 1) or DEB_SHORT_CYC cycles (bit 4 = 0). A shorter excursion produces no vector.
- R4: Pin p (p = 0..3) issues a falling-edge vector of b and a rising-edge vector of b+4, where b = p for p < 2 and b = p+6 otherwise (0,1,8,9 falling; 4,5,12,13 rising).
- R5: Register 1 holds the enables for pins 0 and 1, and register 2 holds those for pins 2 and 3. Within each register, bit k is the falling-edge enable and bit 4+k the rising-edge enable of its k-th pin (k = 0,1). Bits 2,3,6,7 are ignored. An edge that occurs while disabled is discarded and never issued later.
- R6: Among pending requests the order, highest first, is power-on, pin0 fall, pin0 rise, pin1 fall, pin1 rise, pin2 fall, pin2 rise, pin3 fall, pin3 rise, software jump.
- R7: `vec_valid_o` is high for exactly one cycle per vector. No new strobe occurs until `vec_ack_i` has been high at a clock edge after the strobe. Pending requests are kept meanwhile.
- R8: A one-cycle `jump_req_i` latches `jump_vec_i` and issues it as a vector at the lowest priority.
- R9: Writes use `cfg_we` with `cfg_addr` 0 (mode), 1 (enables of pins 0,1) and 2 (enables of pins 2,3). Address 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_i | input | 4 | Raw trigger pins, idle high |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Register write data |
| jump_req_i | input | 1 | Software jump request pulse |
| jump_vec_i | input | 8 | Target vector of the jump request |
| vec_ack_i | input | 1 | Consumer acknowledge of the outstanding vector |
| vec_valid_o | output | 1 | One-cycle strobe for a new vector |
| vec_o | output | 8 | Vector number, valid with the strobe |

## Verification
The assertions assume a few things about the inputs. `vec_ack_i` is pulsed only after a strobe. `jump_req_i` is a single-cycle pulse. Trigger pins move only between whole debounce windows, unless a glitch is the subject of the test. The stimulus keeps to these rules: it acknowledges each vector once, after a monitor has captured it. It holds every deliberate pin level well beyond the active window, and it makes glitches clearly shorter than the short window. Priority is exercised by piling up several requests while one vector is held unacknowledged, and by releasing several pins in the same cycle.

// File: rtl/tva_pkg.sv
package tva_pkg;
  localparam int NPIN     = 4;
  localparam int NSRC     = 2 * NPIN + 2;
  localparam int IDX_POI  = 0;
  localparam int IDX_JUMP = NSRC - 1;
  localparam int VW       = 8;
  localparam logic [VW-1:0] POI_VEC = 8'd32;

  // Fixed vector of edge source idx (1..2*NPIN); idx 0 is power-on
  function automatic logic [VW-1:0] src_vec(input int idx);
    int p;
    int base;
    if (idx == IDX_POI) return POI_VEC;
    p    = (idx - 1) / 2;
    base = (p < 2) ? p : p + 6;
    if (((idx - 1) % 2) == 1) base = base + 4;
    return VW'(base);
  endfunction
endpackage

// File: rtl/tva_debounce.sv
module tva_debounce #(
  parameter int LONG_CYC  = 40,
  parameter int SHORT_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  input  logic long_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = $clog2(LONG_CYC + 1);

  logic [1:0]    sync_q;
  logic          lvl_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;
  logic          flip;

  assign lim  = long_i ? CW'(LONG_CYC) : CW'(SHORT_CYC);
  assign flip = (sync_q[1] != lvl_q) && (cnt_q >= lim - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      lvl_q  <= 1'b1;
      cnt_q  <= '0;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      rise_o <= flip && sync_q[1];
      fall_o <= flip && !sync_q[1];
      if (flip) begin
        lvl_q <= sync_q[1];
        cnt_q <= '0;
      end else if (sync_q[1] != lvl_q) begin
        cnt_q <= cnt_q + CW'(1);
      end else begin
        cnt_q <= '0;
      end
    end
  end

  // R3
  lvl_follows_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl_q) |-> (lvl_q == $past(sync_q[1])));
  // R3
  edge_matches_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o |-> lvl_q) and (fall_o |-> !lvl_q));
  // R3
  edge_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_o && fall_o));
endmodule

// File: rtl/tva_regs.sv
module tva_regs
  import tva_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we_i,
  input  logic [1:0]      addr_i,
  input  logic [7:0]      wdata_i,
  output logic            long_o,
  output logic [NPIN-1:0] fall_en_o,
  output logic [NPIN-1:0] rise_en_o
);
  logic [7:0] mode_q;
  logic [7:0] en_q [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 8'hFF;
      en_q[0] <= 8'h33;
      en_q[1] <= 8'h33;
    end else if (we_i) begin
      case (addr_i)
        2'd0: mode_q <= wdata_i;
        2'd1: en_q[0] <= wdata_i & 8'h33;
        2'd2: en_q[1] <= wdata_i & 8'h33;
        default: ;
      endcase
    end
  end

  assign long_o = mode_q[4];

  for (genvar p = 0; p < NPIN; p++) begin : g_map
    assign fall_en_o[p] = en_q[p / 2][p % 2];
    assign rise_en_o[p] = en_q[p / 2][4 + (p % 2)];
  end
endmodule

// File: rtl/tva_arbiter.sv
module tva_arbiter
  import tva_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] en_i,
  input  logic [VW-1:0]   jump_vec_i,
  input  logic            ack_i,
  output logic            valid_o,
  output logic [VW-1:0]   vec_o
);
  logic [NSRC-1:0] pend_q, clr, gsrc_q;
  logic            busy_q, found;
  logic [VW-1:0]   jvec_q;
  int              gidx;

  always_comb begin
    found = 1'b0;
    gidx  = 0;
    for (int i = 0; i < NSRC; i++) begin
      if (!found && pend_q[i]) begin
        found = 1'b1;
        gidx  = i;
      end
    end
    clr = '0;
    if (!busy_q && found) clr[gidx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      busy_q  <= 1'b0;
      valid_o <= 1'b0;
      vec_o   <= '0;
      jvec_q  <= '0;
      gsrc_q  <= '0;
    end else begin
      pend_q  <= (pend_q & ~clr) | (set_i & en_i);
      valid_o <= 1'b0;
      if (set_i[IDX_JUMP]) jvec_q <= jump_vec_i;
      if (busy_q) begin
        if (ack_i) busy_q <= 1'b0;
      end else if (found) begin
        busy_q  <= 1'b1;
        valid_o <= 1'b1;
        gsrc_q  <= clr;
        vec_o   <= (gidx == IDX_JUMP) ? jvec_q : src_vec(gidx);
      end
    end
  end

  // R7
  strobe_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  // R7
  wait_for_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !ack_i) |=> !valid_o);
  // R6
  no_skip_higher_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (($countones(gsrc_q) == 1) && ((($past(pend_q)) & (gsrc_q - 1'b1)) == '0)));
  // R5
  for (genvar i = 0; i < NSRC; i++) begin : g_en_chk
    // R5
    pend_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q[i]) |-> $past(en_i[i]));
  end
endmodule

// File: rtl/trig_vec_arb.sv
module trig_vec_arb
  import tva_pkg::*;
#(
  parameter int DEB_LONG_CYC  = 40,
  parameter int DEB_SHORT_CYC = 8,
  parameter int POI_DELAY_CYC = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] trig_i,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_addr,
  input  logic [7:0]      cfg_wdata,
  input  logic            jump_req_i,
  input  logic [VW-1:0]   jump_vec_i,
  input  logic            vec_ack_i,
  output logic            vec_valid_o,
  output logic [VW-1:0]   vec_o
);
  localparam int PW = $clog2(POI_DELAY_CYC + 1);

  logic            long_sel;
  logic [NPIN-1:0] fall_en, rise_en, rise, fall;
  logic [NSRC-1:0] set_v, en_v;
  logic [PW-1:0]   poi_cnt_q;
  logic            poi_done_q, poi_set;

  tva_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .addr_i(cfg_addr),
    .wdata_i(cfg_wdata), .long_o(long_sel),
    .fall_en_o(fall_en), .rise_en_o(rise_en)
  );

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    tva_debounce #(.LONG_CYC(DEB_LONG_CYC), .SHORT_CYC(DEB_SHORT_CYC)) u_deb (
      .clk(clk), .rst_n(rst_n), .raw_i(trig_i[p]), .long_i(long_sel),
      .rise_o(rise[p]), .fall_o(fall[p])
    );
    assign set_v[1 + 2*p] = fall[p];
    assign set_v[2 + 2*p] = rise[p];
    assign en_v[1 + 2*p]  = fall_en[p];
    assign en_v[2 + 2*p]  = rise_en[p];
  end

  assign poi_set         = !poi_done_q && (poi_cnt_q == PW'(POI_DELAY_CYC - 1));
  assign set_v[IDX_POI]  = poi_set;
  assign set_v[IDX_JUMP] = jump_req_i;
  assign en_v[IDX_POI]   = 1'b1;
  assign en_v[IDX_JUMP]  = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poi_cnt_q  <= '0;
      poi_done_q <= 1'b0;
    end else if (!poi_done_q) begin
      poi_cnt_q <= poi_cnt_q + PW'(1);
      if (poi_set) poi_done_q <= 1'b1;
    end
  end

  tva_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .set_i(set_v), .en_i(en_v),
    .jump_vec_i(jump_vec_i), .ack_i(vec_ack_i),
    .valid_o(vec_valid_o), .vec_o(vec_o)
  );

  // R2
  poi_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poi_done_q |=> (poi_done_q && !poi_set));
  // R2
  poi_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o && !poi_done_q) |-> 1'b0);
endmodule

// File: tb/trig_vec_arb_tb.sv
module trig_vec_arb_tb;
  localparam int LNG = 40;
  localparam int SHT = 8;
  localparam int POI = 20;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [3:0] trig_i = 4'hF;
  logic       cfg_we = 0;
  logic [1:0] cfg_addr = 0;
  logic [7:0] cfg_wdata = 0;
  logic       jump_req_i = 0;
  logic [7:0] jump_vec_i = 0;
  logic       vec_ack_i = 0;
  logic       vec_valid_o;
  logic [7:0] vec_o;

  int checks = 0;
  int fails = 0;
  logic [7:0] seen[$];
  int strobe_run = 0;
  int long_strobes = 0;
  int cyc = 0;
  int first_cyc = -1;

  always #4 clk = ~clk;

  trig_vec_arb #(.DEB_LONG_CYC(LNG), .DEB_SHORT_CYC(SHT), .POI_DELAY_CYC(POI)) u_dut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .jump_req_i(jump_req_i),
    .jump_vec_i(jump_vec_i), .vec_ack_i(vec_ack_i),
    .vec_valid_o(vec_valid_o), .vec_o(vec_o)
  );

  always @(negedge clk) begin
    if (rst_n) cyc <= cyc + 1;
    if (vec_valid_o) begin
      seen.push_back(vec_o);
      if (first_cyc < 0) first_cyc = cyc;
      strobe_run = strobe_run + 1;
      if (strobe_run > 1) long_strobes = long_strobes + 1;
    end else strobe_run = 0;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ack();
    vec_ack_i = 1;
    @(negedge clk);
    vec_ack_i = 0;
  endtask

  task automatic want(input int exp, input string req, input bit do_ack = 1);
    int n = 0;
    while (seen.size() == 0 && n < 400) begin
      @(negedge clk);
      n++;
    end
    if (seen.size() == 0) check(0, req, -1, exp);
    else begin
      logic [7:0] v = seen.pop_front();
      check(v == exp, req, v, exp);
      if (do_ack) ack();
    end
  endtask

  task automatic none(input int n, input string req);
    repeat (n) @(negedge clk);
    check(seen.size() == 0, req, seen.size(), 0);
    seen.delete();
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  function automatic int fvec(input int p);
    return (p < 2) ? p : p + 6;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check(vec_valid_o == 0, "R1 reset", vec_valid_o, 0);
    rst_n = 1;
    repeat (POI - 4) @(negedge clk);
    check(seen.size() == 0, "R1 quiet before power-on", seen.size(), 0);
    want(32, "R2 power-on vector");
    check(first_cyc >= POI && first_cyc <= POI + 3, "R2 power-on delay", first_cyc, POI);
    none(200, "R2 power-on only once");

    // R4 sweep over every pin and both edges (defaults: all enabled, long)
    for (int p = 0; p < 4; p++) begin
      trig_i[p] = 0;
      want(fvec(p), "R4 falling vector");
      trig_i[p] = 1;
      want(fvec(p) + 4, "R4 rising vector");
    end

    // R3 long mode: excursion longer than short, shorter than long
    trig_i[3] = 0; repeat (LNG / 2) @(negedge clk); trig_i[3] = 1;
    none(150, "R3 long window rejects short pulse");
    wr(2'd0, 8'hEF);
    trig_i[3] = 0; repeat (SHT / 2) @(negedge clk); trig_i[3] = 1;
    none(100, "R3 short window rejects glitch");
    trig_i[3] = 0; repeat (LNG / 2) @(negedge clk); trig_i[3] = 1;
    want(9, "R3 short window accepts fall");
    want(13, "R3 short window accepts rise");
    wr(2'd3, 8'h00);
    trig_i[3] = 0; repeat (LNG / 2) @(negedge clk); trig_i[3] = 1;
    want(9, "R9 address 3 ignored (fall)");
    want(13, "R9 address 3 ignored (rise)");
    wr(2'd0, 8'hFF);

    // R5 enables
    wr(2'd1, 8'hFE);
    trig_i[0] = 0; none(120, "R5 disabled fall discarded");
    trig_i[0] = 1; want(4, "R5 rise still enabled");
    wr(2'd1, 8'hFF);
    none(100, "R5 disabled fall not pending later");
    wr(2'd2, 8'hCC);
    trig_i[2] = 0; none(120, "R5 only ignored bits set: fall off");
    trig_i[2] = 1; none(120, "R5 only ignored bits set: rise off");
    wr(2'd2, 8'h20);
    trig_i[3] = 0; none(120, "R5 pin3 fall bit1 clear");
    trig_i[3] = 1; want(13, "R5 pin3 rise bit5 set");
    wr(2'd2, 8'hFF);

    // R6/R7/R8 priority under back-pressure
    trig_i[1] = 0;
    want(1, "R7 first vector held", 0);
    trig_i[0] = 0; trig_i[2] = 0;
    jump_vec_i = 8'hA7; jump_req_i = 1; @(negedge clk); jump_req_i = 0;
    none(150, "R7 no strobe before ack");
    ack();
    want(0, "R6 pin0 fall first");
    want(8, "R6 pin2 fall next");
    want(8'hA7, "R8 jump vector last");
    trig_i[0] = 1; trig_i[1] = 1; trig_i[2] = 1;
    want(4, "R6 rise order pin0");
    want(5, "R6 rise order pin1");
    want(12, "R6 rise order pin2");
    jump_vec_i = 8'h5C; jump_req_i = 1; @(negedge clk); jump_req_i = 0;
    jump_vec_i = 8'h00;
    want(8'h5C, "R8 jump alone");
    ack();
    none(50, "R7 spurious ack ignored");
    check(long_strobes == 0, "R7 strobe one cycle", long_strobes, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R7 watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule